// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two operands of `W` bits (32 by default) into a product of `2W` bits. It does this serially, handling one multiplier bit per clock. It uses a single adder one bit wider than an operand and one double-width product register. At load time the multiplier sits in the low half of that register. Each step shifts the multiplier out of the bottom while the partial product grows in from the top. Because the multiplier and the product share the register, the adder only ever works on the upper half.

A one-cycle `start` while the unit is idle captures both operands and the mode. The unit then runs exactly `W` steps and pulses `done`. The result appears as two separate words, `prodHi` and `prodLo`, which a processor can read with separate move-from-high and move-from-low operations. Both words stay unchanged until the next accepted `start`.

In signed mode the operands are two's complement. Each right shift copies the sign of the partial product instead of shifting in zero. The last step subtracts the multiplicand when the multiplier's top bit is set, because that bit carries negative weight.

Top module: `shift_add_mul`

## Requirements
- R1: While `rstN` is low and after its release, `busy` and `done` are 0 and `prodHi`/`prodLo` are all zeros.
- R2: A `start` sampled high while `busy` is 0 captures the operands. In the next cycle, `prodLo` equals the multiplier, `prodHi` is zero and `busy` is 1.
- R3: `done` rises exactly `W` clock edges after the edge that accepted `start`. It is high for a single cycle, and `busy` is 0 whenever `done` is 1.
- R4: With `signedMode` 0 at start, the value {`prodHi`,`prodLo`} at `done` equals the unsigned product of the operands. For example, 0x7FFFFFFF times 0x40000000 gives `prodHi` 0x1FFFFFFF and `prodLo` 0xC0000000. The sum of each step keeps its carry-out, so all-ones times all-ones is exact.
- R5: With `signedMode` 1 at start, the value {`prodHi`,`prodLo`} at `done` equals the two's-complement product of the operands. This includes the most negative value times itself.
- R6: A `start` while `busy` is 1 is ignored: the operand values applied with it have no effect on the result, and `done` still rises on the original schedule.
- R7: After `done`, `prodHi` and `prodLo` hold their values until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication when idle |
| signedMode | input | 1 | 1 = two's-complement operands, 0 = unsigned; sampled with start |
| multiplicand | input | W | Multiplicand operand, sampled with start |
| multiplier | input | W | Multiplier operand, sampled with start |
| busy | output | 1 | High while steps are in progress |
| done | output | 1 | One-cycle pulse when the product is complete |
| prodHi | output | W | Upper word of the product register |
| prodLo | output | W | Lower word of the product register |

## Verification
On every cycle the assertions check the following:
- the load image of the register;
- that `done` lasts one cycle and never coincides with `busy`;
- that a step always follows a busy cycle up to the pulse;
- that a start during busy never reaches the datapath;
- that the register holds while idle.

The arithmetic itself is shown only by the bench scenarios:
- an exhaustive sweep of every operand pair of a 4-bit instance, in both modes;
- corner and random operands on the 32-bit instance, compared with products computed in the bench;
- a mid-run start carrying different operands, which must leave the result unchanged.

// File: rtl/mul_pkg.sv
package mul_pkg;
  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic load;      // capture operands, clear upper half
    logic step;      // perform one add/shift iteration
    logic lastStep;  // current iteration handles the multiplier's top bit
  } mulStrobes_t;
endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import mul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output mulStrobes_t strobes,
  output logic        busy,
  output logic        done
);
  localparam int CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic             busyQ;
  logic             doneQ;
  logic [CNT_W-1:0] cntQ;

  always_comb begin
    strobes.load     = start && !busyQ;
    strobes.step     = busyQ;
    strobes.lastStep = busyQ && (cntQ == LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      doneQ <= 1'b0;
      cntQ  <= '0;
    end else begin
      doneQ <= 1'b0;
      if (strobes.load) begin
        busyQ <= 1'b1;
        cntQ  <= '0;
      end else if (busyQ) begin
        if (strobes.lastStep) begin
          busyQ <= 1'b0;
          doneQ <= 1'b1;
        end else begin
          cntQ <= cntQ + 1'b1;
        end
      end
    end
  end

  assign busy = busyQ;
  assign done = doneQ;

  // R3: done lasts a single cycle
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);
  // R3: done never overlaps busy
  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> !busyQ);
  // R3: a busy cycle is followed by more work or by the done pulse
  p_busy_progress_r3: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |=> (busyQ || doneQ));
  // R3: iteration counter stays inside the step range
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> (cntQ <= LAST));
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath
  import mul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  mulStrobes_t   strobes,
  input  logic          signedMode,
  input  logic [W-1:0]  multiplicand,
  input  logic [W-1:0]  multiplier,
  output logic [W-1:0]  prodHi,
  output logic [W-1:0]  prodLo
);
  localparam int PW = 2 * W;

  logic [PW-1:0] prodQ;
  logic [W-1:0]  mcandQ;
  logic          signedQ;

  // Upper half and multiplicand extended by one bit: carry (unsigned) or sign (signed)
  logic [W:0]    upperX;
  logic [W:0]    mcandX;
  logic [W:0]    sumX;
  logic [W:0]    keepX;
  logic [PW-1:0] prodNext;

  always_comb begin
    upperX   = {signedQ & prodQ[PW-1], prodQ[PW-1:W]};
    mcandX   = {signedQ & mcandQ[W-1], mcandQ};
    sumX     = (signedQ && strobes.lastStep) ? (upperX - mcandX) : (upperX + mcandX);
    keepX    = prodQ[0] ? sumX : upperX;
    prodNext = {keepX, prodQ[W-1:1]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prodQ   <= '0;
      mcandQ  <= '0;
      signedQ <= 1'b0;
    end else if (strobes.load) begin
      prodQ   <= {{W{1'b0}}, multiplier};
      mcandQ  <= multiplicand;
      signedQ <= signedMode;
    end else if (strobes.step) begin
      prodQ   <= prodNext;
    end
  end

  assign prodHi = prodQ[PW-1:W];
  assign prodLo = prodQ[W-1:0];

  // R2: loading places the multiplier low and clears the upper half
  p_load_image_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (prodLo == $past(multiplier)) && (prodHi == '0));
  // R7: the product register holds when no load or step is requested
  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.load && !strobes.step) |=> $stable(prodQ));
  // R6: operands stay fixed throughout a run
  p_operands_fixed_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step |=> ($stable(mcandQ) && $stable(signedQ)));
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul
  import mul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         signedMode,
  input  logic [W-1:0] multiplicand,
  input  logic [W-1:0] multiplier,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] prodHi,
  output logic [W-1:0] prodLo
);
  mulStrobes_t strobes;

  mul_ctrl #(.W(W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .strobes (strobes),
    .busy    (busy),
    .done    (done)
  );

  mul_datapath #(.W(W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .signedMode   (signedMode),
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .prodHi       (prodHi),
    .prodLo       (prodLo)
  );

  // R6: a start seen while busy never turns into a load
  p_no_reload_r6: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strobes.load);
  // R1: nothing is flagged in the first cycle after reset release
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> (!busy && !done));
endmodule

// File: tb/test_shift_add_mul.sv
module test_shift_add_mul;
  localparam int  W        = 32;
  localparam int  WS       = 4;
  localparam time CLK_T    = 10ns;
  localparam int  WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_T / 2) clk = ~clk;

  // 32-bit instance
  logic          start = 1'b0, sgn = 1'b0;
  logic [W-1:0]  mA = '0, mB = '0;
  logic          busy, done;
  logic [W-1:0]  pHi, pLo;

  shift_add_mul #(.W(W)) i_shift_add_mul (
    .clk(clk), .rstN(rstN), .start(start), .signedMode(sgn),
    .multiplicand(mA), .multiplier(mB),
    .busy(busy), .done(done), .prodHi(pHi), .prodLo(pLo));

  // small instance for the exhaustive sweep
  logic          sStart = 1'b0, sSgn = 1'b0;
  logic [WS-1:0] sA = '0, sB = '0;
  logic          sBusy, sDone;
  logic [WS-1:0] sHi, sLo;

  shift_add_mul #(.W(WS)) i_shift_add_mul_small (
    .clk(clk), .rstN(rstN), .start(sStart), .signedMode(sSgn),
    .multiplicand(sA), .multiplier(sB),
    .busy(sBusy), .done(sDone), .prodHi(sHi), .prodLo(sLo));

  int nChecks = 0;
  int nFail   = 0;
  int cycles  = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual 0x%016h expected 0x%016h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  function automatic logic [63:0] expect32(input logic [W-1:0] a, input logic [W-1:0] b, input logic s);
    logic [63:0] xa, xb;
    xa = s ? {{32{a[W-1]}}, a} : {32'b0, a};
    xb = s ? {{32{b[W-1]}}, b} : {32'b0, b};
    return xa * xb;
  endfunction

  // One full 32-bit operation with timing checks; optional mid-run start with other operands.
  task automatic runOp(input logic [W-1:0] a, input logic [W-1:0] b, input logic s, input bit inject);
    logic [63:0] exp;
    logic [63:0] got;
    exp = expect32(a, b, s);
    @(negedge clk);
    mA = a; mB = b; sgn = s; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(pLo == b && pHi == '0 && busy, "R2 load image", {pHi, pLo}, {32'b0, b});
    for (int k = 1; k <= W; k++) begin
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      if (k < W) begin
        if (done) chk(1'b0, "R3 early done", 64'(k), 64'(W));
      end else begin
        chk(done && !busy, "R3 done timing", {62'b0, done, busy}, 64'h2);
        got = {pHi, pLo};
        chk(got == exp, s ? "R5 signed product" : "R4 unsigned product", got, exp);
        if (inject) chk(got == exp, "R6 start while busy ignored", got, exp);
      end
      if (inject && k == 5) begin
        mA = ~a; mB = ~b; sgn = ~s; start = 1'b1;
      end
    end
    // R7 / R3: pulse ends, product held while inputs wander
    mA = a ^ 32'h5A5A_5A5A; mB = b + 32'd7;
    @(posedge clk);
    @(negedge clk);
    chk(!done, "R3 done single cycle", {63'b0, done}, 64'h0);
    chk({pHi, pLo} == exp, "R7 product held", {pHi, pLo}, exp);
  endtask

  task automatic runSmall(input logic [WS-1:0] a, input logic [WS-1:0] b, input logic s);
    logic [7:0] exp;
    logic [7:0] xa, xb;
    xa  = s ? {{4{a[WS-1]}}, a} : {4'b0, a};
    xb  = s ? {{4{b[WS-1]}}, b} : {4'b0, b};
    exp = xa * xb;
    @(negedge clk);
    sA = a; sB = b; sSgn = s; sStart = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sStart = 1'b0;
    for (int k = 1; k <= WS; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
    chk(sDone && {sHi, sLo} == exp, s ? "R5 small signed sweep" : "R4 small unsigned sweep",
        {55'b0, sDone, sHi, sLo}, {55'b0, 1'b1, exp});
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && !done && pHi == '0 && pLo == '0, "R1 reset state", {pHi, pLo}, 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done && pHi == '0 && pLo == '0, "R1 after release", {62'b0, busy, done}, 64'h0);

    // R4 corners
    runOp(32'h7FFF_FFFF, 32'h4000_0000, 1'b0, 1'b0);
    chk(pHi == 32'h1FFF_FFFF && pLo == 32'hC000_0000, "R4 worked example", {pHi, pLo}, 64'h1FFF_FFFF_C000_0000);
    runOp(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0);
    runOp(32'h0, 32'hFFFF_FFFF, 1'b0, 1'b0);
    runOp(32'hFFFF_FFFF, 32'h1, 1'b0, 1'b0);
    // R5 corners
    runOp(32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0);
    runOp(32'hFFFF_FFFF, 32'h8000_0000, 1'b1, 1'b0);
    runOp(32'h7FFF_FFFF, 32'h8000_0000, 1'b1, 1'b0);
    runOp(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0);
    runOp(32'h0000_0003, 32'hFFFF_FFFB, 1'b1, 1'b0);
    // R6: mid-run starts with different operands
    runOp(32'h1234_5678, 32'h9ABC_DEF0, 1'b0, 1'b1);
    runOp(32'hDEAD_BEEF, 32'h0BAD_F00D, 1'b1, 1'b1);
    // random operands, both modes
    for (int i = 0; i < 60; i++) begin
      runOp($urandom, $urandom, 1'(i & 1), 1'b0);
    end
    // exhaustive small sweep, both modes
    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          runSmall(4'(a), 4'(b), 1'(s));
        end
      end
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule